// File: doc/BRIEF.md
# Iteration-Granular Write Power Token Manager

This block manages the current budget of a multi-level-cell phase-change memory module during writes. The module may draw at most a fixed number of RESET-equivalent units of current at once; the block keeps that budget as a token pool. Each write is a RESET pulse followed by a short series of SET-and-verify iterations, and fewer cells take part in each later iteration. A write request carries the number of cells in its RESET and in each SET iteration. The block hands out tokens one program step at a time. Tokens are given back as soon as cells converge, so several writes can overlap whenever their current step demands fit the pool together.

A request is loaded into one of a small set of write slots. Each slot runs a state machine with four states. `SL_IDLE` means the slot is free. `SL_WAIT` means the slot is waiting for tokens for its next step. `SL_RESET` and `SL_SET` are the running program steps, each timed by a down-counter. The transitions are: load (IDLE to WAIT), grant (WAIT to RESET or SET), shrink-continue (step end to the next step while keeping part of the tokens), give-back (step end to WAIT with all tokens returned) and finish (step end to IDLE). A shared age matrix picks the oldest waiting slot for the one grant allowed per cycle. A per-request split flag lets the RESET be done in partial chunks. A pool counter nets all grants and releases of a cycle into one update.

Top module: `wtm_token_mgr`

## Requirements
- R1: After reset, `free_tokens` equals POOL, every held count is zero, `grant_valid` and `done_vec` are low and `req_ready` is high.
- R2: A request is refused if any SET iteration count exceeds POOL, or if its RESET count exceeds POOL while `req_split` is 0. A refused request raises `req_err` in the same cycle as `req_valid`, takes no slot and takes no tokens.
- R3: In every cycle, `free_tokens` plus the sum of all held counts equals POOL, and `free_tokens` never exceeds POOL.
- R4: A write without the split flag is granted a step only when the step's whole cell count fits in `free_tokens`. The cycle after the grant, its slot holds exactly that count.
- R5: A RESET step lasts RESET_CYC cycles and a SET step lasts SET_CYC cycles. A lone write accepted at edge e0 pulses its `done_vec` bit in the cycle that starts at edge e0 + (number of RESET steps)·RESET_CYC + (number of SET steps)·SET_CYC + (number of wait cycles between steps).
- R6: When a step ends, if the next step's count is no larger than the tokens held, the slot keeps exactly that count, returns the rest at that edge and starts the next step with no gap. Otherwise it returns all its tokens and waits for a new grant.
- R7: A write finishes after its last SET iteration, or at the first SET iteration whose count is zero. Its `done_vec` bit pulses for one cycle and its held count is zero from the next cycle.
- R8: Waiting writes are granted strictly in acceptance order. A younger write that would fit is not granted while an older one is waiting.
- R9: With `req_split` set, a RESET chunk is granted whenever at least one token is free, or when zero RESET cells remain. The chunk size is the smaller of the remaining RESET cells and `free_tokens`.
- R10: Tokens returned by one slot and tokens granted to another at the same edge are netted into a single pool update.
- R11: A new request takes the lowest-numbered idle slot. `req_ready` is low while every slot is busy. In the packed ports, slot i lives at bits [i·TKW +: TKW] of `held_flat` and bit i of `done_vec`, and SET iteration k lives at bits [k·CW +: CW] of `req_set_cells`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_split | input | 1 | Allow the RESET to be done in partial chunks |
| req_reset_cells | input | CW | Cells in the RESET pulse |
| req_set_cells | input | MAX_ITER·CW | Cells in each SET iteration, iteration k at [k·CW +: CW] |
| req_ready | output | 1 | At least one slot is idle |
| req_err | output | 1 | Request refused because a step exceeds the pool |
| grant_valid | output | 1 | A grant is taken at the coming edge |
| grant_slot | output | SW | Slot receiving the grant |
| grant_tokens | output | TKW | Tokens granted |
| done_vec | output | NS | Per-slot completion pulse |
| held_flat | output | NS·TKW | Tokens held by each slot |
| free_tokens | output | TKW | Tokens left in the pool |

## Verification
The bench aims at the step boundaries. One case is a SET count larger than the RESET chunk, which must send the slot back to waiting for one cycle; a design that just kept going would overdraw the pool. Another is a zero count that must end a write early; a design that ignored it would run extra steps and report done late. The bench lines up one slot's release with another slot's grant on the same edge. A pool that applied only one of the two would be off by the returned amount. It also lets a small younger write arrive behind a large waiting one: a greedy arbiter would let it jump the queue. Split-mode RESETs larger than the pool check that chunks are sized to what is free, rather than refused or left waiting for ever.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_WAIT  = 2'd1,
        SL_RESET = 2'd2,
        SL_SET   = 2'd3
    } slot_state_e;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wtm_slot.sv
module wtm_slot
    import wtm_pkg::*;
#(
    parameter int CW        = 10,
    parameter int TKW       = 10,
    parameter int MAX_ITER  = 4,
    parameter int RESET_CYC = 500,
    parameter int SET_CYC   = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   ld_split,
    input  logic [CW-1:0]          ld_reset,
    input  logic [MAX_ITER*CW-1:0] ld_set,
    input  logic                   grant,
    input  logic [TKW-1:0]         grant_amt,
    output logic                   idle,
    output logic                   waiting,
    output logic                   split_ph,
    output logic [CW-1:0]          demand,
    output logic [TKW-1:0]         held,
    output logic [TKW-1:0]         release_amt,
    output logic                   done
);
    localparam int DW  = max_i(CW, TKW);
    localparam int IW  = $clog2(MAX_ITER + 1);
    localparam int TMW = $clog2(max_i(RESET_CYC, SET_CYC) + 1);

    slot_state_e                  st_q, st_n;
    logic [TKW-1:0]               held_q, held_n;
    logic [CW-1:0]                rleft_q, rleft_n;
    logic                         rph_q, rph_n;
    logic                         split_q;
    logic [IW-1:0]                it_q, it_n;
    logic [TMW-1:0]               tm_q, tm_n;
    logic [MAX_ITER-1:0][CW-1:0]  set_q;

    logic [DW-1:0] rl_after, d_after, held_ext;
    logic          rph_after;
    logic [IW-1:0] it_after;

    function automatic logic [CW-1:0] sel_set(input logic [IW-1:0] idx);
        logic [CW-1:0] r;
        r = '0;
        for (int k = 0; k < MAX_ITER; k++) begin
            if (idx == IW'(k)) r = set_q[k];
        end
        return r;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SL_IDLE;
            held_q  <= '0;
            rleft_q <= '0;
            rph_q   <= 1'b0;
            split_q <= 1'b0;
            it_q    <= '0;
            tm_q    <= '0;
            set_q   <= '0;
        end else begin
            st_q    <= st_n;
            held_q  <= held_n;
            rleft_q <= rleft_n;
            rph_q   <= rph_n;
            it_q    <= it_n;
            tm_q    <= tm_n;
            if (load && st_q == SL_IDLE) begin
                split_q <= ld_split;
                for (int k = 0; k < MAX_ITER; k++) begin
                    set_q[k] <= ld_set[k*CW +: CW];
                end
            end
        end
    end

    // what the slot needs once the running step ends
    always_comb begin
        held_ext  = DW'(held_q);
        rl_after  = (st_q == SL_RESET) ? (DW'(rleft_q) - held_ext) : DW'(rleft_q);
        rph_after = (st_q == SL_RESET) && (rl_after != '0);
        it_after  = (st_q == SL_SET) ? (it_q + IW'(1)) : it_q;
        if (rph_after)
            d_after = rl_after;
        else if (it_after == IW'(MAX_ITER))
            d_after = '0;
        else
            d_after = DW'(sel_set(it_after));
    end

    // next state and outputs
    always_comb begin
        st_n        = st_q;
        held_n      = held_q;
        rleft_n     = rleft_q;
        rph_n       = rph_q;
        it_n        = it_q;
        tm_n        = tm_q;
        release_amt = '0;
        done        = 1'b0;
        unique case (st_q)
            SL_IDLE: begin
                if (load) begin
                    st_n    = SL_WAIT;
                    rleft_n = ld_reset;
                    rph_n   = 1'b1;
                    it_n    = '0;
                    held_n  = '0;
                end
            end
            SL_WAIT: begin
                if (grant) begin
                    held_n = grant_amt;
                    st_n   = rph_q ? SL_RESET : SL_SET;
                    tm_n   = rph_q ? TMW'(RESET_CYC - 1) : TMW'(SET_CYC - 1);
                end
            end
            SL_RESET, SL_SET: begin
                if (tm_q != '0) begin
                    tm_n = tm_q - TMW'(1);
                end else begin
                    rleft_n = CW'(rl_after);
                    rph_n   = rph_after;
                    it_n    = it_after;
                    if (d_after == '0) begin
                        release_amt = held_q;
                        held_n      = '0;
                        done        = 1'b1;
                        st_n        = SL_IDLE;
                    end else if (d_after <= held_ext) begin
                        release_amt = held_q - TKW'(d_after);
                        held_n      = TKW'(d_after);
                        st_n        = rph_after ? SL_RESET : SL_SET;
                        tm_n        = rph_after ? TMW'(RESET_CYC - 1) : TMW'(SET_CYC - 1);
                    end else begin
                        release_amt = held_q;
                        held_n      = '0;
                        st_n        = SL_WAIT;
                    end
                end
            end
        endcase
    end

    assign idle     = (st_q == SL_IDLE);
    assign waiting  = (st_q == SL_WAIT);
    assign split_ph = split_q && rph_q;
    assign demand   = rph_q ? rleft_q : sel_set(it_q);
    assign held     = held_q;

endmodule

// File: rtl/wtm_arbiter.sv
module wtm_arbiter
    import wtm_pkg::*;
#(
    parameter int NS  = 4,
    parameter int CW  = 10,
    parameter int TKW = 10,
    parameter int SW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS-1:0]     load_vec,
    input  logic [NS-1:0]     waiting,
    input  logic [NS-1:0]     split_ph,
    input  logic [NS*CW-1:0]  demand_flat,
    input  logic [TKW-1:0]    free,
    output logic [NS-1:0]     grant_vec,
    output logic              grant_valid,
    output logic [SW-1:0]     grant_slot,
    output logic [TKW-1:0]    grant_amt
);
    localparam int DW = max_i(CW, TKW);

    // older_q[i][j] set: slot i was accepted before slot j
    logic [NS-1:0][NS-1:0] older_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int k = 0; k < NS; k++) begin
                if (load_vec[k]) begin
                    for (int j = 0; j < NS; j++) begin
                        if (j != k) begin
                            older_q[k][j] <= 1'b0;
                            older_q[j][k] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    logic          found;
    int            head;
    logic          is_oldest;
    logic          fits;
    logic [DW-1:0] dem, fr;

    always_comb begin
        found = 1'b0;
        head  = 0;
        for (int i = 0; i < NS; i++) begin
            is_oldest = waiting[i];
            for (int j = 0; j < NS; j++) begin
                if (j != i && waiting[j] && !older_q[i][j]) is_oldest = 1'b0;
            end
            if (is_oldest && !found) begin
                found = 1'b1;
                head  = i;
            end
        end
        dem = DW'(demand_flat[head*CW +: CW]);
        fr  = DW'(free);
        if (split_ph[head]) begin
            fits      = (dem == '0) || (fr != '0);
            grant_amt = (dem < fr) ? TKW'(dem) : free;
        end else begin
            fits      = (dem <= fr);
            grant_amt = TKW'(dem);
        end
        grant_valid = found && fits;
        grant_slot  = SW'(head);
        grant_vec   = '0;
        if (grant_valid) grant_vec[head] = 1'b1;
    end

endmodule

// File: rtl/wtm_pool.sv
module wtm_pool #(
    parameter int NS   = 4,
    parameter int TKW  = 10,
    parameter int POOL = 560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS*TKW-1:0] release_flat,
    input  logic              grant_valid,
    input  logic [TKW-1:0]    grant_amt,
    output logic [TKW-1:0]    free
);
    localparam int SUMW = TKW + $clog2(NS + 1) + 1;

    logic [TKW-1:0]  free_q;
    logic [SUMW-1:0] rel_sum, nxt;

    always_comb begin
        rel_sum = '0;
        for (int i = 0; i < NS; i++) begin
            rel_sum = rel_sum + SUMW'(release_flat[i*TKW +: TKW]);
        end
        nxt = SUMW'(free_q) + rel_sum - (grant_valid ? SUMW'(grant_amt) : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            free_q <= TKW'(POOL);
        else if (nxt > SUMW'(POOL))
            free_q <= TKW'(POOL);
        else
            free_q <= TKW'(nxt);
    end

    assign free = free_q;

endmodule

// File: rtl/wtm_token_mgr.sv
module wtm_token_mgr #(
    parameter int NS        = 4,
    parameter int POOL      = 560,
    parameter int MAX_ITER  = 4,
    parameter int MAX_CELLS = 1023,
    parameter int RESET_CYC = 500,
    parameter int SET_CYC   = 1000,
    localparam int CW  = $clog2(MAX_CELLS + 1),
    localparam int TKW = $clog2(POOL + 1),
    localparam int SW  = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_split,
    input  logic [CW-1:0]          req_reset_cells,
    input  logic [MAX_ITER*CW-1:0] req_set_cells,
    output logic                   req_ready,
    output logic                   req_err,
    output logic                   grant_valid,
    output logic [SW-1:0]          grant_slot,
    output logic [TKW-1:0]         grant_tokens,
    output logic [NS-1:0]          done_vec,
    output logic [NS*TKW-1:0]      held_flat,
    output logic [TKW-1:0]         free_tokens
);
    logic [NS-1:0]     idle_vec, wait_vec, split_vec, grant_vec, load_vec;
    logic [NS*CW-1:0]  demand_flat;
    logic [NS*TKW-1:0] release_flat;
    logic              too_big;
    int                pick;

    always_comb begin
        too_big = !req_split && (int'(req_reset_cells) > POOL);
        for (int k = 0; k < MAX_ITER; k++) begin
            if (int'(req_set_cells[k*CW +: CW]) > POOL) too_big = 1'b1;
        end
        pick = 0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (idle_vec[i]) pick = i;
        end
        req_ready = |idle_vec;
        req_err   = req_valid && req_ready && too_big;
        load_vec  = '0;
        if (req_valid && req_ready && !too_big) load_vec[pick] = 1'b1;
    end

    for (genvar g = 0; g < NS; g++) begin : g_slot
        wtm_slot #(
            .CW(CW), .TKW(TKW), .MAX_ITER(MAX_ITER),
            .RESET_CYC(RESET_CYC), .SET_CYC(SET_CYC)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_vec[g]),
            .ld_split   (req_split),
            .ld_reset   (req_reset_cells),
            .ld_set     (req_set_cells),
            .grant      (grant_vec[g]),
            .grant_amt  (grant_tokens),
            .idle       (idle_vec[g]),
            .waiting    (wait_vec[g]),
            .split_ph   (split_vec[g]),
            .demand     (demand_flat[g*CW +: CW]),
            .held       (held_flat[g*TKW +: TKW]),
            .release_amt(release_flat[g*TKW +: TKW]),
            .done       (done_vec[g])
        );
    end

    wtm_arbiter #(.NS(NS), .CW(CW), .TKW(TKW), .SW(SW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_vec   (load_vec),
        .waiting    (wait_vec),
        .split_ph   (split_vec),
        .demand_flat(demand_flat),
        .free       (free_tokens),
        .grant_vec  (grant_vec),
        .grant_valid(grant_valid),
        .grant_slot (grant_slot),
        .grant_amt  (grant_tokens)
    );

    wtm_pool #(.NS(NS), .TKW(TKW), .POOL(POOL)) u_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .release_flat(release_flat),
        .grant_valid (grant_valid),
        .grant_amt   (grant_tokens),
        .free        (free_tokens)
    );

endmodule

// File: rtl/wtm_token_mgr_chk.sv
module wtm_token_mgr_chk #(
    parameter int NS   = 4,
    parameter int TKW  = 10,
    parameter int POOL = 560,
    parameter int SW   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_err,
    input logic              grant_valid,
    input logic [SW-1:0]     grant_slot,
    input logic [TKW-1:0]    grant_tokens,
    input logic [NS-1:0]     done_vec,
    input logic [NS*TKW-1:0] held_flat,
    input logic [TKW-1:0]    free_tokens
);
    localparam int SUMW = TKW + $clog2(NS + 1) + 1;

    logic [SUMW-1:0] held_sum;
    logic            gv_q;
    logic [SW-1:0]   gs_q;
    logic [TKW-1:0]  gt_q;
    logic [TKW-1:0]  held_sel;

    always_comb begin
        held_sum = '0;
        for (int i = 0; i < NS; i++) held_sum = held_sum + SUMW'(held_flat[i*TKW +: TKW]);
        held_sel = held_flat[int'(gs_q)*TKW +: TKW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gv_q <= 1'b0;
            gs_q <= '0;
            gt_q <= '0;
        end else begin
            gv_q <= grant_valid;
            gs_q <= grant_slot;
            gt_q <= grant_tokens;
        end
    end

    p_conserve_r3: assert property (@(posedge clk) disable iff (!rst_n)
        held_sum + SUMW'(free_tokens) == SUMW'(POOL));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_tokens) <= POOL);
    p_grant_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_tokens <= free_tokens);
    p_grant_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gv_q |-> held_sel == gt_q);
    p_err_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_valid && req_ready));

    for (genvar g = 0; g < NS; g++) begin : g_slot_chk
        p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            done_vec[g] |=> held_flat[g*TKW +: TKW] == '0);
        p_grow_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (held_flat[g*TKW +: TKW] > $past(held_flat[g*TKW +: TKW]))
            |-> ($past(grant_valid) && $past(grant_slot) == SW'(g)));
    end

endmodule

bind wtm_token_mgr wtm_token_mgr_chk #(
    .NS(NS), .TKW(TKW), .POOL(POOL), .SW(SW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_err     (req_err),
    .grant_valid (grant_valid),
    .grant_slot  (grant_slot),
    .grant_tokens(grant_tokens),
    .done_vec    (done_vec),
    .held_flat   (held_flat),
    .free_tokens (free_tokens)
);

// File: tb/wtm_token_mgr_bench.sv
module wtm_token_mgr_bench;
    localparam int NS = 3, POOL = 60, MI = 3, MC = 127, RL = 4, SL = 6;
    localparam int CW = 7, TKW = 6, SW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_split = 1'b0;
    logic [CW-1:0]     req_reset_cells = '0;
    logic [MI*CW-1:0]  req_set_cells = '0;
    logic              req_ready, req_err, grant_valid;
    logic [SW-1:0]     grant_slot;
    logic [TKW-1:0]    grant_tokens, free_tokens;
    logic [NS-1:0]     done_vec;
    logic [NS*TKW-1:0] held_flat;

    int n_checks = 0, n_fail = 0;

    always #2 clk = ~clk;

    wtm_token_mgr #(.NS(NS), .POOL(POOL), .MAX_ITER(MI), .MAX_CELLS(MC),
                    .RESET_CYC(RL), .SET_CYC(SL)) u_wtm_token_mgr (.*);

    // {split, reset, s0, s1, s2, err, done cycle, held in C1, held in C(RL+1)}
    localparam logic [51:0] VEC [8] = '{
        {1'b0, 7'd40, 7'd25, 7'd10, 7'd0,  1'b0, 8'd16, 7'd40, 7'd25},
        {1'b0, 7'd60, 7'd60, 7'd60, 7'd60, 1'b0, 8'd22, 7'd60, 7'd60},
        {1'b0, 7'd61, 7'd5,  7'd0,  7'd0,  1'b1, 8'd0,  7'd0,  7'd0},
        {1'b1, 7'd61, 7'd20, 7'd5,  7'd1,  1'b0, 8'd27, 7'd60, 7'd1},
        {1'b0, 7'd10, 7'd30, 7'd0,  7'd0,  1'b0, 8'd11, 7'd10, 7'd0},
        {1'b0, 7'd0,  7'd0,  7'd0,  7'd0,  1'b0, 8'd4,  7'd0,  7'd0},
        {1'b0, 7'd5,  7'd61, 7'd0,  7'd0,  1'b1, 8'd0,  7'd0,  7'd0},
        {1'b0, 7'd20, 7'd15, 7'd0,  7'd9,  1'b0, 8'd10, 7'd20, 7'd15}
    };

    function automatic int held(input int i);
        return int'(held_flat[i*TKW +: TKW]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit sp, input int r, input int s0, input int s1, input int s2);
        req_valid       = 1'b1;
        req_split       = sp;
        req_reset_cells = CW'(r);
        req_set_cells   = {CW'(s2), CW'(s1), CW'(s0)};
    endtask

    task automatic send(input bit sp, input int r, input int s0, input int s1, input int s2);
        drive(sp, r, s0, s1, s2);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain;
        int t;
        t = 0;
        while (int'(free_tokens) != POOL && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(int'(free_tokens) == POOL, "R3 pool refilled", int'(free_tokens), POOL);
        wait_neg(2);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(int'(free_tokens) == POOL, "R1 free", int'(free_tokens), POOL);
        chk(held_flat == '0, "R1 held", int'(held_flat), 0);
        chk(!grant_valid && done_vec == '0, "R1 grant/done", int'(grant_valid), 0);
        chk(req_ready, "R1 ready", int'(req_ready), 1);

        // table walk: lone writes in slot 0
        for (int t = 0; t < 8; t++) begin
            logic [51:0] v;
            int k;
            bit seen;
            v = VEC[t];
            drive(v[51], int'(v[50:44]), int'(v[43:37]), int'(v[36:30]), int'(v[29:23]));
            #1;
            chk(req_err == v[22], "R2 err flag", int'(req_err), int'(v[22]));
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            if (v[22]) begin
                chk(int'(free_tokens) == POOL, "R2 no tokens taken", int'(free_tokens), POOL);
                chk(held(0) == 0, "R2 no slot used", held(0), 0);
            end else begin
                k = 0;
                seen = 1'b0;
                while (!seen && k < 200) begin
                    if (k == 1)
                        chk(held(0) == int'(v[13:7]), "R4 R9 first grant", held(0), int'(v[13:7]));
                    if (k == RL + 1 && int'(v[21:14]) > RL + 1)
                        chk(held(0) == int'(v[6:0]), "R6 held after reset", held(0), int'(v[6:0]));
                    if (done_vec[0]) seen = 1'b1;
                    else begin
                        @(negedge clk);
                        k++;
                    end
                end
                chk(k == int'(v[21:14]), "R5 R7 done cycle", k, int'(v[21:14]));
                @(negedge clk);
                chk(held(0) == 0 && int'(free_tokens) == POOL, "R7 tokens returned",
                    held(0), 0);
            end
            wait_neg(1);
        end

        // R10 same-edge netting, R11 slot order
        send(1'b0, 30, 10, 0, 0);
        send(1'b0, 20, 5, 0, 0);
        wait_neg(2);
        send(1'b0, 5, 5, 0, 0);
        wait_neg(1);
        chk(int'(free_tokens) == 25, "R10 netted pool", int'(free_tokens), 25);
        chk(held(0) == 10, "R6 slot0 shrunk", held(0), 10);
        chk(held(1) == 20, "R11 slot1 held", held(1), 20);
        chk(held(2) == 5, "R11 slot2 held", held(2), 5);
        chk(!req_ready, "R11 ready low when full", int'(req_ready), 0);
        drain();

        // R8 arrival order
        send(1'b0, 50, 50, 0, 0);
        send(1'b0, 40, 5, 0, 0);
        send(1'b0, 5, 5, 0, 0);
        wait_neg(1);
        chk(held(2) == 0 && held(1) == 0, "R8 young write held back", held(2), 0);
        chk(int'(free_tokens) == 10, "R4 waiter takes nothing", int'(free_tokens), 10);
        wait_neg(8);
        chk(held(2) == 0, "R8 still behind older", held(2), 0);
        wait_neg(2);
        chk(held(1) == 40, "R8 older granted first", held(1), 40);
        chk(held(2) == 5, "R8 younger granted next", held(2), 5);
        drain();

        // R9 split RESET chunks
        send(1'b0, 50, 50, 0, 0);
        send(1'b1, 30, 5, 0, 0);
        wait_neg(1);
        chk(held(1) == 10, "R9 first chunk", held(1), 10);
        chk(int'(free_tokens) == 0, "R9 pool empty", int'(free_tokens), 0);
        wait_neg(5);
        chk(held(1) == 10, "R9 second chunk", held(1), 10);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule